// File: doc/BRIEF.md
# Block-Cipher Round Sequencer

This block is the control state machine that walks a sixteen-round Feistel block cipher through one encryption or one decryption. It does not hold data or key material. It drives the control pins of a neighbouring datapath: the selects of the two half-block input multiplexers, the load enables of the left and right half registers, and a done flag. It also drives the enable and the count direction of an external key-index counter, whose present value it reads back to find the last round.

An operation starts with a one-cycle start request in the idle state. The direction bit sampled at that moment picks one of two paths. Each path has a one-cycle setup state, in which the half registers load the fresh block through the multiplexers with select 0 and the key counter is enabled. It then has a round state, in which the half registers take the round feedback with select 1. Encryption counts the key index up and leaves on the value ROUNDS-1. Decryption counts it down and leaves on 0. A result state then raises done for one cycle and returns to idle. Every output comes from a register, so the datapath sees glitch-free controls that line up with the state.

Top module: `des_seq_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the block in idle. After the first clock edge with reset high, all seven outputs are 0.
- R2: In idle all outputs are 0, including both multiplexer selects. Without a start request the block stays in idle.
- R3: A start request in idle with direction bit 1 enters encrypt setup after the next edge. Encrypt setup lasts exactly one cycle with outputs {sel_l,sel_r,ld_l,ld_r,cnt_en,enc_en,done} = 0011110.
- R4: A start request in idle with direction bit 0 enters decrypt setup. Decrypt setup lasts one cycle with outputs 0011100, so the count direction is down.
- R5: The encrypt round state drives outputs 1111110. It stays in place on every cycle where the round index is not ROUNDS-1 (15 by default).
- R6: The decrypt round state drives outputs 1111100. It stays in place on every cycle where the round index is not 0.
- R7: A round state moves to the result state after the edge at which the round index equals its own terminal value: 15 for encrypt, 0 for decrypt. The other direction's terminal value does not end the rounds. With an index that steps once per round, the register load enables are high for exactly 16 cycles.
- R8: The result state drives outputs 0000001, with done high for exactly one cycle and both load enables low. The block then returns to idle.
- R9: The start request and the direction bit are ignored in every state except idle. This includes the result cycle. A start request there does not begin a new operation, and a direction change during an operation does not alter enc_en.
- R10: Reset asserted in the middle of an operation returns the block to idle, with all outputs 0, after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only in idle |
| mode_enc_i | input | 1 | Direction: 1 encrypt, 0 decrypt; sampled with start |
| round_idx_i | input | CNT_W | Present value of the external key-index counter |
| sel_l_o | output | 1 | Left-half multiplexer select (0 fresh block, 1 round feedback) |
| sel_r_o | output | 1 | Right-half multiplexer select |
| ld_l_o | output | 1 | Left-half register load enable |
| ld_r_o | output | 1 | Right-half register load enable |
| cnt_en_o | output | 1 | Key-index counter enable |
| enc_en_o | output | 1 | Encrypt mode and counter direction (1 up, 0 down) |
| done_o | output | 1 | One-cycle completion flag |

## Verification
Two events can fall in the same cycle. One is the completion of an operation. The other is the request for the next one, whether a start pulse during the result cycle or during a round, or a terminal counter value arriving while a start pulse is held high. The bench raises start in the very cycle in which done is high. It also pulses start and flips the direction bit in the middle of rounds. A behavioural model, which honours start only in idle, is compared with all seven outputs on every clock. Explicit checks then confirm that the cycle after done shows idle rather than a setup state, and that the load enables were high for exactly the expected number of round cycles.

// File: rtl/desctl_pkg.sv
package desctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_ENC_SETUP = 3'd1,
    ST_DEC_SETUP = 3'd2,
    ST_ENC_RND   = 3'd3,
    ST_DEC_RND   = 3'd4,
    ST_FINAL     = 3'd5
  } ctl_state_t;

  typedef struct packed {
    logic sel_l;
    logic sel_r;
    logic ld_l;
    logic ld_r;
    logic cnt_en;
    logic enc_en;
    logic done;
  } ctl_out_t;

endpackage

// File: rtl/des_ctl_next.sv
module des_ctl_next
  import desctl_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int ROUNDS = 16
) (
  input  ctl_state_t       cur,
  input  logic             start_i,
  input  logic             mode_i,
  input  logic [CNT_W-1:0] idx_i,
  output ctl_state_t       nxt
);

  localparam logic [CNT_W-1:0] LAST_UP = CNT_W'(ROUNDS - 1);
  localparam logic [CNT_W-1:0] LAST_DN = '0;

  always_comb begin
    nxt = cur;
    case (cur)
      ST_IDLE:      if (start_i) nxt = mode_i ? ST_ENC_SETUP : ST_DEC_SETUP;
      ST_ENC_SETUP: nxt = ST_ENC_RND;
      ST_DEC_SETUP: nxt = ST_DEC_RND;
      ST_ENC_RND:   if (idx_i == LAST_UP) nxt = ST_FINAL;
      ST_DEC_RND:   if (idx_i == LAST_DN) nxt = ST_FINAL;
      ST_FINAL:     nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/des_ctl_decode.sv
module des_ctl_decode
  import desctl_pkg::*;
(
  input  ctl_state_t st,
  output ctl_out_t   ctl
);

  always_comb begin
    ctl = '0;
    case (st)
      ST_ENC_SETUP: begin
        ctl.ld_l = 1'b1;  ctl.ld_r = 1'b1;
        ctl.cnt_en = 1'b1; ctl.enc_en = 1'b1;
      end
      ST_DEC_SETUP: begin
        ctl.ld_l = 1'b1;  ctl.ld_r = 1'b1;
        ctl.cnt_en = 1'b1;
      end
      ST_ENC_RND: begin
        ctl.sel_l = 1'b1; ctl.sel_r = 1'b1;
        ctl.ld_l = 1'b1;  ctl.ld_r = 1'b1;
        ctl.cnt_en = 1'b1; ctl.enc_en = 1'b1;
      end
      ST_DEC_RND: begin
        ctl.sel_l = 1'b1; ctl.sel_r = 1'b1;
        ctl.ld_l = 1'b1;  ctl.ld_r = 1'b1;
        ctl.cnt_en = 1'b1;
      end
      ST_FINAL: ctl.done = 1'b1;
      default:  ctl = '0;
    endcase
  end

endmodule

// File: rtl/des_ctl_regs.sv
module des_ctl_regs
  import desctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  ctl_state_t nxt,
  input  ctl_out_t   nxt_ctl,
  output ctl_state_t state_q,
  output ctl_out_t   ctl_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ctl_q   <= '0;
    end else begin
      state_q <= nxt;
      ctl_q   <= nxt_ctl;
    end
  end

  // R1 and R10: reset from any state lands in idle with quiet outputs
  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (state_q == ST_IDLE && ctl_q == '0));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_q.done |=> !ctl_q.done);

  assert_final_to_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FINAL) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/des_seq_ctrl.sv
module des_seq_ctrl
  import desctl_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int ROUNDS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             mode_enc_i,
  input  logic [CNT_W-1:0] round_idx_i,
  output logic             sel_l_o,
  output logic             sel_r_o,
  output logic             ld_l_o,
  output logic             ld_r_o,
  output logic             cnt_en_o,
  output logic             enc_en_o,
  output logic             done_o
);

  localparam logic [CNT_W-1:0] LAST_UP = CNT_W'(ROUNDS - 1);
  localparam logic [CNT_W-1:0] LAST_DN = '0;

  ctl_state_t state_q;
  ctl_state_t nxt;
  ctl_out_t   nxt_ctl;
  ctl_out_t   ctl_q;

  des_ctl_next #(.CNT_W(CNT_W), .ROUNDS(ROUNDS)) u_next (
    .cur    (state_q),
    .start_i(start_i),
    .mode_i (mode_enc_i),
    .idx_i  (round_idx_i),
    .nxt    (nxt)
  );

  // decode the upcoming state so every output leaves a flop
  des_ctl_decode u_dec (
    .st (nxt),
    .ctl(nxt_ctl)
  );

  des_ctl_regs u_regs (
    .clk    (clk),
    .rst    (rst),
    .nxt    (nxt),
    .nxt_ctl(nxt_ctl),
    .state_q(state_q),
    .ctl_q  (ctl_q)
  );

  assign sel_l_o  = ctl_q.sel_l;
  assign sel_r_o  = ctl_q.sel_r;
  assign ld_l_o   = ctl_q.ld_l;
  assign ld_r_o   = ctl_q.ld_r;
  assign cnt_en_o = ctl_q.cnt_en;
  assign enc_en_o = ctl_q.enc_en;
  assign done_o   = ctl_q.done;

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (!sel_l_o && !sel_r_o && !ld_l_o && !done_o));

  assert_enc_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_i && mode_enc_i)
      |=> (state_q == ST_ENC_SETUP && enc_en_o && cnt_en_o && !sel_l_o));

  assert_dec_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && start_i && !mode_enc_i)
      |=> (state_q == ST_DEC_SETUP && !enc_en_o && cnt_en_o && !sel_r_o));

  assert_enc_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ENC_RND && round_idx_i != LAST_UP)
      |=> (state_q == ST_ENC_RND && enc_en_o && ld_l_o));

  assert_dec_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DEC_RND && round_idx_i != LAST_DN)
      |=> (state_q == ST_DEC_RND && !enc_en_o && ld_r_o));

  assert_enc_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ENC_RND && round_idx_i == LAST_UP) |=> done_o);

  assert_dec_exit_R7: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DEC_RND && round_idx_i == LAST_DN) |=> done_o);

  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE)
      |=> (state_q != ST_ENC_SETUP && state_q != ST_DEC_SETUP));

endmodule

// File: tb/des_seq_ctrl_tb.sv
module des_seq_ctrl_tb;

  localparam int CNT_W  = 4;
  localparam int ROUNDS = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode = 1'b0;
  logic [CNT_W-1:0] idx = '0;
  logic sel_l, sel_r, ld_l, ld_r, cnt_en, enc_en, done;

  int errors = 0;
  int checks = 0;
  int rnd_cnt = 0;
  int done_cnt = 0;
  int m_st = 0;
  bit chk_on = 1'b0;

  always #4 clk = ~clk;

  des_seq_ctrl #(.CNT_W(CNT_W), .ROUNDS(ROUNDS)) u_dut (
    .clk(clk), .rst(rst), .start_i(start), .mode_enc_i(mode),
    .round_idx_i(idx), .sel_l_o(sel_l), .sel_r_o(sel_r),
    .ld_l_o(ld_l), .ld_r_o(ld_r), .cnt_en_o(cnt_en),
    .enc_en_o(enc_en), .done_o(done)
  );

  wire [6:0] outs = {sel_l, sel_r, ld_l, ld_r, cnt_en, enc_en, done};

  // model states: 0 idle, 1 enc setup, 2 dec setup, 3 enc rounds, 4 dec rounds, 5 result
  function automatic logic [6:0] exp_of(int s);
    case (s)
      1: return 7'b0011110;
      2: return 7'b0011100;
      3: return 7'b1111110;
      4: return 7'b1111100;
      5: return 7'b0000001;
      default: return 7'b0000000;
    endcase
  endfunction

  function automatic string tag_of(int s);
    case (s)
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R8";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) m_st <= 0;
    else begin
      case (m_st)
        0: if (start) m_st <= mode ? 1 : 2;
        1: m_st <= 3;
        2: m_st <= 4;
        3: if (idx == CNT_W'(ROUNDS - 1)) m_st <= 5;
        4: if (idx == '0) m_st <= 5;
        5: m_st <= 0;
        default: m_st <= 0;
      endcase
    end
  end

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk(tag_of(m_st), outs, exp_of(m_st));
      if (ld_l && sel_l) rnd_cnt++;
      if (done) done_cnt++;
    end
  end

  task automatic step(input logic s, input logic m, input int i);
    @(negedge clk);
    start = s;
    mode = m;
    idx = CNT_W'(i);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_on = 1'b1;
    chk("R1", outs, 7'b0);
    // R2: idle holds without start
    for (int k = 0; k < 4; k++) step(0, k[0], 15);
    chk("R2", outs, 7'b0);

    // encrypt: direction flips and start pulse inside rounds (R9)
    rnd_cnt = 0; done_cnt = 0;
    step(1, 1, 0);
    step(0, 0, 0);
    chk("R3", outs, 7'b0011110);
    for (int r = 0; r < ROUNDS; r++) step(r == 5, r[0], r);
    step(1, 1, 0);              // start coincides with done
    chk("R7", outs, 7'b0000001);
    step(0, 0, 0);
    chk("R9", outs, 7'b0000000);
    chk_int("R7", rnd_cnt, 16);
    chk_int("R8", done_cnt, 1);

    // decrypt: counts down from 15 to 0
    rnd_cnt = 0; done_cnt = 0;
    step(1, 0, 15);
    step(0, 1, 15);
    chk("R4", outs, 7'b0011100);
    for (int r = ROUNDS - 1; r >= 0; r--) step(0, 1, r);
    step(0, 0, 0);
    chk("R7", outs, 7'b0000001);
    step(0, 0, 0);
    chk("R8", outs, 7'b0000000);
    chk_int("R6", rnd_cnt, 16);

    // encrypt with a stalled index: stays in rounds (R5)
    rnd_cnt = 0;
    step(1, 1, 0);
    step(0, 1, 0);
    for (int r = 0; r < ROUNDS; r++) begin
      step(0, 1, r);
      if (r == 7) for (int k = 0; k < 4; k++) step(0, 1, 7);
    end
    step(0, 1, 0);
    step(0, 1, 0);
    chk_int("R5", rnd_cnt, 20);

    // decrypt with encrypt's terminal injected mid-round (R7)
    rnd_cnt = 0;
    step(1, 0, 15);
    step(0, 0, 15);
    step(0, 0, 15);
    step(0, 0, 14);
    step(0, 0, 15);
    chk("R7", outs, 7'b1111100);
    for (int r = 13; r >= 0; r--) step(0, 0, r);
    step(0, 0, 0);
    chk("R7", outs, 7'b0000001);
    step(0, 0, 0);
    chk_int("R6", rnd_cnt, 17);

    // back to back: idle start right after result
    step(1, 1, 0);
    step(0, 1, 0);
    chk("R3", outs, 7'b0011110);
    for (int r = 0; r < ROUNDS; r++) step(0, 1, r);
    step(1, 0, 0);
    chk("R8", outs, 7'b0000001);
    step(1, 0, 15);
    chk("R9", outs, 7'b0000000);
    step(0, 0, 15);
    chk("R4", outs, 7'b0011100);

    // reset in the middle of decrypt rounds
    step(0, 0, 15);
    step(0, 0, 14);
    @(negedge clk);
    rst = 1'b1;
    step(0, 0, 13);
    rst = 1'b0;
    chk("R10", outs, 7'b0000000);
    step(0, 0, 0);
    chk("R10", outs, 7'b0000000);

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule